// File: doc/BRIEF.md
# DMA Completion Interrupt Vector Controller

This block collects completion pulses from eight transmit DMA channels and eight receive DMA channels, plus two MAC-level error sources (host error and status error). It drives one interrupt line to the host. Each source group keeps a latched raw status and a per-bit mask. The mask is changed only through a pair of registers: one sets bits and the other clears them, so a writer never has to read, modify and write the mask.

The host reads a vector word. The word shows which groups have an enabled pending event and gives the number of the lowest pending channel. After servicing, the host acknowledges the channel through the ack strobes and writes the end-of-interrupt register. Once the line has fired, it stays asserted until that write. It then drops for at least one cycle and fires again if enabled work is still pending.

The register port is word-addressed with a 4-bit address. Writes take effect on the clock edge. Reads are combinational from the current state.

Top module: `dma_irq_vec_ctrl`

## Requirements
- R1: After reset every raw status bit and every mask bit is 0, the vector reads 0 and `irq_o` is low.
- R2: An event pulse sets the raw bit of its channel at the next clock edge. An ack strobe clears that bit. When an event and an ack for the same channel arrive in the same cycle, the raw bit ends up set.
- R3: A write to an enable register (TX at address 2, RX at 6, MAC at 10) sets each mask bit written as 1 and leaves bits written as 0 unchanged. Reading either the enable or the clear address of a group returns that group's mask.
- R4: A write to a clear register (TX at address 3, RX at 7, MAC at 11) clears each mask bit written as 1 and leaves bits written as 0 unchanged.
- R5: Raw status reads at address 0/4/8 show latched events regardless of the mask. Masked status reads at address 1/5/9 equal raw AND mask.
- R6: The MAC group has two sources: bit 0 is the host error and bit 1 is the status error. Writing 3 to its enable register enables both.
- R7: The vector word is read at address 12. Bit 16 is set when any TX channel has a masked pending event, bit 17 the same for RX, bit 18 for the masked host error and bit 19 for the masked status error.
- R8: Vector bits 2:0 hold the lowest-numbered pending masked TX channel. When no TX channel is pending they hold the lowest pending masked RX channel, and otherwise 0. All other vector bits are 0.
- R9: While armed, `irq_o` rises one clock edge after any masked status bit becomes set. Once high, it stays high until a write to the end-of-interrupt register (address 13), even if the pending bits are cleared.
- R10: A write to address 13 drops `irq_o` and re-arms the line. If a masked bit is still pending, `irq_o` rises again at the following edge. A write to address 13 with nothing pending leaves `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| tx_evt_i | input | 8 | Transmit channel completion pulses |
| rx_evt_i | input | 8 | Receive channel completion pulses |
| mac_evt_i | input | 2 | MAC source pulses: bit 0 host error, bit 1 status error |
| tx_ack_i | input | 8 | Transmit channel acknowledge strobes |
| rx_ack_i | input | 8 | Receive channel acknowledge strobes |
| mac_ack_i | input | 2 | MAC source acknowledge strobes |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest condition to reach is the window where the line has fired and is waiting for end-of-interrupt while the pending set keeps changing underneath it. The stimulus fires the line, acknowledges the original channel so nothing from it remains, and then raises a new event on another channel. The line must stay high throughout that window. It must then drop for exactly one cycle after the end-of-interrupt write and rise again because of the new event. A table of mask and event mixes drives the priority encoding separately, including cases where events arrive on masked-off channels and cases where TX and RX are pending together.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] GRP_TX_BASE  = 4'd0;
  localparam logic [ADDR_W-1:0] GRP_RX_BASE  = 4'd4;
  localparam logic [ADDR_W-1:0] GRP_MAC_BASE = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_VEC     = 4'd12;
  localparam logic [ADDR_W-1:0] ADDR_EOI     = 4'd13;

  // offsets inside a group
  localparam logic [ADDR_W-1:0] OFS_RAW  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_SET  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 4'd3;

  localparam int unsigned VEC_TX_BIT   = 16;
  localparam int unsigned VEC_RX_BIT   = 17;
  localparam int unsigned VEC_HOST_BIT = 18;
  localparam int unsigned VEC_STAT_BIT = 19;

  localparam int unsigned MAC_SRCS = 2;
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group
  import dma_irq_pkg::*;
#(
  parameter int unsigned     N    = 8,
  parameter logic [ADDR_W-1:0] BASE = 4'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      evt_i,
  input  logic [N-1:0]      ack_i,
  output logic [N-1:0]      raw_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      masked_o
);
  logic set_hit, clr_hit;
  logic [N-1:0] raw_q, mask_q;

  assign set_hit = we_i && (addr_i == BASE + OFS_SET);
  assign clr_hit = we_i && (addr_i == BASE + OFS_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~ack_i) | evt_i;  // new event beats ack
      if (set_hit)      mask_q <= mask_q | wdata_i;
      else if (clr_hit) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N   = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/dma_irq_vec_ctrl.sv
module dma_irq_vec_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_CH-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  input  logic [MAC_SRCS-1:0] mac_evt_i,
  input  logic [NUM_CH-1:0] tx_ack_i,
  input  logic [NUM_CH-1:0] rx_ack_i,
  input  logic [MAC_SRCS-1:0] mac_ack_i,
  output logic              irq_o
);
  logic [NUM_CH-1:0]   tx_raw, tx_mask, tx_masked;
  logic [NUM_CH-1:0]   rx_raw, rx_mask, rx_masked;
  logic [MAC_SRCS-1:0] mac_raw, mac_mask, mac_masked;
  logic [CH_W-1:0]     tx_idx, rx_idx;
  logic                tx_any, rx_any, any_masked;
  logic [DATA_W-1:0]   vec;
  logic                armed_q, irq_q, eoi_wr;

  irq_src_group #(.N(NUM_CH), .BASE(GRP_TX_BASE)) u_tx (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .evt_i(tx_evt_i), .ack_i(tx_ack_i),
    .raw_o(tx_raw), .mask_o(tx_mask), .masked_o(tx_masked));

  irq_src_group #(.N(NUM_CH), .BASE(GRP_RX_BASE)) u_rx (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .evt_i(rx_evt_i), .ack_i(rx_ack_i),
    .raw_o(rx_raw), .mask_o(rx_mask), .masked_o(rx_masked));

  irq_src_group #(.N(MAC_SRCS), .BASE(GRP_MAC_BASE)) u_mac (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[MAC_SRCS-1:0]),
    .evt_i(mac_evt_i), .ack_i(mac_ack_i),
    .raw_o(mac_raw), .mask_o(mac_mask), .masked_o(mac_masked));

  irq_prio_enc #(.N(NUM_CH)) u_tx_enc (.pend_i(tx_masked), .idx_o(tx_idx), .any_o(tx_any));
  irq_prio_enc #(.N(NUM_CH)) u_rx_enc (.pend_i(rx_masked), .idx_o(rx_idx), .any_o(rx_any));

  always_comb begin
    vec               = '0;
    vec[VEC_TX_BIT]   = tx_any;
    vec[VEC_RX_BIT]   = rx_any;
    vec[VEC_HOST_BIT] = mac_masked[0];
    vec[VEC_STAT_BIT] = mac_masked[1];
    vec[CH_W-1:0]     = tx_any ? tx_idx : (rx_any ? rx_idx : '0);
  end

  assign any_masked = tx_any | rx_any | (|mac_masked);
  assign eoi_wr     = reg_we_i && (reg_addr_i == ADDR_EOI);

  // line latches on fire, held until EOI re-arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (eoi_wr) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (armed_q && any_masked) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b1;
    end
  end
  assign irq_o = irq_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      GRP_TX_BASE  + OFS_RAW: reg_rdata_o = DATA_W'(tx_raw);
      GRP_TX_BASE  + OFS_MSK: reg_rdata_o = DATA_W'(tx_masked);
      GRP_TX_BASE  + OFS_SET,
      GRP_TX_BASE  + OFS_CLR: reg_rdata_o = DATA_W'(tx_mask);
      GRP_RX_BASE  + OFS_RAW: reg_rdata_o = DATA_W'(rx_raw);
      GRP_RX_BASE  + OFS_MSK: reg_rdata_o = DATA_W'(rx_masked);
      GRP_RX_BASE  + OFS_SET,
      GRP_RX_BASE  + OFS_CLR: reg_rdata_o = DATA_W'(rx_mask);
      GRP_MAC_BASE + OFS_RAW: reg_rdata_o = DATA_W'(mac_raw);
      GRP_MAC_BASE + OFS_MSK: reg_rdata_o = DATA_W'(mac_masked);
      GRP_MAC_BASE + OFS_SET,
      GRP_MAC_BASE + OFS_CLR: reg_rdata_o = DATA_W'(mac_mask);
      ADDR_VEC:               reg_rdata_o = vec;
      default:                reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_vec_ctrl_chk.sv
module dma_irq_vec_ctrl_chk
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [NUM_CH-1:0] reg_wdata_i,
  input logic [NUM_CH-1:0] tx_evt_i,
  input logic [NUM_CH-1:0] tx_raw,
  input logic [NUM_CH-1:0] tx_mask,
  input logic [NUM_CH-1:0] tx_masked,
  input logic              any_masked,
  input logic [DATA_W-1:0] vec,
  input logic              irq_o
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);
  logic set_wr, clr_wr, eoi_wr;
  assign set_wr = reg_we_i && (reg_addr_i == GRP_TX_BASE + OFS_SET);
  assign clr_wr = reg_we_i && (reg_addr_i == GRP_TX_BASE + OFS_CLR);
  assign eoi_wr = reg_we_i && (reg_addr_i == ADDR_EOI);

  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_evt_i) |=> ((tx_raw & $past(tx_evt_i)) == $past(tx_evt_i))); // R2
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((tx_mask & $past(reg_wdata_i)) == $past(reg_wdata_i))); // R3
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((tx_mask & ~$past(reg_wdata_i)) == ($past(tx_mask) & ~$past(reg_wdata_i)))); // R3
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((tx_mask & $past(reg_wdata_i)) == '0)); // R4
  AST_VEC_TX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec[VEC_TX_BIT] |-> (tx_masked[vec[CH_W-1:0]] &&
      ((tx_masked & ((ONE << vec[CH_W-1:0]) - ONE)) == '0))); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !eoi_wr) |=> irq_o); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_masked)); // R9
  AST_EOI_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && eoi_wr) |=> !irq_o); // R10
  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(eoi_wr)); // R10
endmodule

bind dma_irq_vec_ctrl dma_irq_vec_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .tx_evt_i(tx_evt_i), .tx_raw(tx_raw),
  .tx_mask(tx_mask), .tx_masked(tx_masked), .any_masked(any_masked),
  .vec(vec), .irq_o(irq_o));

// File: tb/dma_irq_vec_ctrl_tb.sv
module dma_irq_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0] tx_evt = '0, rx_evt = '0, tx_ack = '0, rx_ack = '0;
  logic [1:0] mac_evt = '0, mac_ack = '0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_vec_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_evt_i(tx_evt),
    .rx_evt_i(rx_evt), .mac_evt_i(mac_evt), .tx_ack_i(tx_ack),
    .rx_ack_i(rx_ack), .mac_ack_i(mac_ack), .irq_o(irq));

  typedef struct packed {
    logic [7:0]  tx_en;
    logic [7:0]  rx_en;
    logic [7:0]  tx_ev;
    logic [7:0]  rx_ev;
    logic [1:0]  mac_en;
    logic [1:0]  mac_ev;
    logic [31:0] vec;
  } case_t;

  localparam case_t TBL [7] = '{
    '{8'hFF, 8'h00, 8'h28, 8'h00, 2'd0, 2'd0, 32'h0001_0003},
    '{8'h0F, 8'hFF, 8'hF0, 8'h40, 2'd0, 2'd0, 32'h0002_0006},
    '{8'h80, 8'h02, 8'h80, 8'h03, 2'd0, 2'd0, 32'h0003_0007},
    '{8'h00, 8'h00, 8'h00, 8'h00, 2'd3, 2'd1, 32'h0004_0000},
    '{8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 2'd3, 32'h0008_0000},
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 2'd0, 2'd3, 32'h0000_0000},
    '{8'h00, 8'h81, 8'h00, 8'h81, 2'd0, 2'd0, 32'h0002_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cleanup();
    wr(4'd3, 8'hFF); wr(4'd7, 8'hFF); wr(4'd11, 8'h03);
    tx_ack = '1; rx_ack = '1; mac_ack = '1;
    @(negedge clk);
    tx_ack = '0; rx_ack = '0; mac_ack = '0;
    wr(4'd13, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'd0, d);  check("R1 tx raw", d, 32'd0);
    rd(4'd2, d);  check("R1 tx mask", d, 32'd0);
    rd(4'd12, d); check("R1 vector", d, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R5 R6 R7 R8 R9
    foreach (TBL[i]) begin
      wr(4'd2, TBL[i].tx_en); wr(4'd6, TBL[i].rx_en); wr(4'd10, {6'd0, TBL[i].mac_en});
      tx_evt = TBL[i].tx_ev; rx_evt = TBL[i].rx_ev; mac_evt = TBL[i].mac_ev;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; mac_evt = '0;
      @(negedge clk);
      rd(4'd12, d); check($sformatf("R7 R8 vector row %0d", i), d, TBL[i].vec);
      rd(4'd1, d);  check($sformatf("R5 tx masked row %0d", i), d, {24'd0, TBL[i].tx_en & TBL[i].tx_ev});
      rd(4'd4, d);  check($sformatf("R5 rx raw row %0d", i), d, {24'd0, TBL[i].rx_ev});
      rd(4'd9, d);  check($sformatf("R6 mac masked row %0d", i), d, {30'd0, TBL[i].mac_en & TBL[i].mac_ev});
      check($sformatf("R9 irq row %0d", i), {31'd0, irq}, {31'd0, TBL[i].vec != 0});
      cleanup();
    end

    // R3 set with zero bits kept, readback at both addresses
    wr(4'd2, 8'h0F); wr(4'd2, 8'h30);
    rd(4'd2, d); check("R3 set keep", d, 32'h3F);
    // R4 clear
    wr(4'd3, 8'h05);
    rd(4'd3, d); check("R4 clear", d, 32'h3A);
    rd(4'd2, d); check("R3 readback", d, 32'h3A);
    wr(4'd3, 8'hFF);

    // R2 event beats ack, ack alone clears
    tx_evt = 8'h10; @(negedge clk); tx_evt = '0;
    tx_evt = 8'h10; tx_ack = 8'h10; @(negedge clk); tx_evt = '0; tx_ack = '0;
    rd(4'd0, d); check("R2 event wins", d, 32'h10);
    tx_ack = 8'h10; @(negedge clk); tx_ack = '0;
    rd(4'd0, d); check("R2 ack clears", d, 32'h0);
    check("R9 no irq while masked", {31'd0, irq}, 32'd0);

    // R9 R10 line hold and re-arm
    wr(4'd2, 8'h06);
    tx_evt = 8'h02; @(negedge clk); tx_evt = '0;
    check("R9 not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R9 rise", {31'd0, irq}, 32'd1);
    tx_ack = 8'h02; @(negedge clk); tx_ack = '0;
    @(negedge clk);
    check("R9 held w/o pending", {31'd0, irq}, 32'd1);
    tx_evt = 8'h04; @(negedge clk); tx_evt = '0;
    repeat (3) @(negedge clk);
    check("R10 no refire before eoi", {31'd0, irq}, 32'd1);
    wr(4'd13, 8'h00);
    check("R10 drop after eoi", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R10 refire pending", {31'd0, irq}, 32'd1);
    rd(4'd12, d); check("R8 ch2", d, 32'h0001_0002);
    tx_ack = 8'h04; @(negedge clk); tx_ack = '0;
    wr(4'd13, 8'h00);
    repeat (3) @(negedge clk);
    check("R10 quiet eoi", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule